// File: doc/BRIEF.md
# Endpoint Buffer Prime and Flush Control

This block holds the software-facing request and status words for a small device-side serial bus controller with three endpoints. Each endpoint has a receive and a transmit direction. Software writes ones to request that a buffer be made ready (a prime) or that every ready buffer be discarded (a flush). Each pending request is shown to that endpoint's engine as a level request. The engine answers with a one-cycle done pulse. The block clears the request bit on that pulse, so software learns that an operation has finished by seeing its bit drop.

A read-only status word shows which endpoint directions currently hold a ready buffer. A successful prime sets the status bit and a successful flush clears it. A flush is not passed to the engine while a packet is still moving on that endpoint direction, so a transfer is never cut off. When a flush and a prime are both pending on the same endpoint direction, the flush goes first. The engine can also raise a prime bit by itself when it re-primes automatically after a descriptor retires.

Top module: `ep_prime_flush_ctrl`

## Requirements
- R1: After reset, all three words read as zero and no prime or flush request is raised.
- R2: The prime word is at address 0, the flush word at address 1 and the status word at address 2. In each word, bit n (n = 0..2) is the receive side of endpoint n and bit 16+n is the transmit side of endpoint n. Every other bit reads as zero and ignores writes. Channel vectors on the engine ports put receive endpoint n at index n and transmit endpoint n at index 3+n.
- R3: Writing a one to a prime bit sets it, and the matching prime_req rises after that write's clock edge. Writing a zero leaves the bit unchanged.
- R4: A prime_done pulse on a channel whose prime_req is high clears the prime bit and sets the status bit at the same edge.
- R5: A pending flush raises flush_req only while pkt_busy is low for that channel. While the packet is busy, the flush bit stays set.
- R6: A flush_done pulse on a channel whose flush_req is high clears the flush bit and the status bit at the same edge.
- R7: While a flush is pending on a channel, prime_req for that channel stays low. It rises once the flush completes.
- R8: A one-cycle auto_prime pulse sets the matching prime bit, which then behaves like a software prime until it is done.
- R9: If a software write of one and a done pulse land on the same bit in the same cycle, the bit stays set.
- R10: Writes to the status address change nothing.
- R11: reg_rdata shows the word selected by reg_addr at the previous clock edge (one-cycle read latency). Address 3 reads zero.
- R12: A done pulse on a channel with no raised request changes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Word address |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| prime_req | output | 6 | Prime request per channel |
| prime_done | input | 6 | Prime success pulse per channel |
| flush_req | output | 6 | Flush request per channel |
| flush_done | input | 6 | Flush success pulse per channel |
| pkt_busy | input | 6 | Packet in progress per channel |
| auto_prime | input | 6 | Hardware re-prime pulse per channel |

## Verification
A write, done pulse or auto-prime pulse takes effect at the next rising edge. The request outputs and the status bits are decoded straight from the registers, so the bench drives stimulus at a falling edge, lets one rising edge pass, and samples requests at the following falling edge. Read data carries one more register stage. The read task therefore sets the address, waits one rising edge and samples at the next falling edge. A separate check confirms that a change of address shows nothing until the following edge.

// File: rtl/epf_pkg.sv
package epf_pkg;
  localparam int EPF_NUM_EP = 3;
  localparam int EPF_NCH    = 2 * EPF_NUM_EP;
  localparam int EPF_DW     = 32;
  localparam int EPF_AW     = 2;
  localparam int EPF_RX_LSB = 0;
  localparam int EPF_TX_LSB = 16;

  typedef logic [EPF_NCH-1:0] ch_vec_t;
  typedef logic [EPF_DW-1:0]  word_t;

  typedef enum logic [EPF_AW-1:0] {
    SEL_PRIME = 2'd0,
    SEL_FLUSH = 2'd1,
    SEL_STAT  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // Word bit layout -> channel vector {tx, rx}
  function automatic ch_vec_t word_to_ch(input word_t w);
    ch_vec_t c;
    c[EPF_NUM_EP-1:0]       = w[EPF_RX_LSB +: EPF_NUM_EP];
    c[EPF_NCH-1:EPF_NUM_EP] = w[EPF_TX_LSB +: EPF_NUM_EP];
    return c;
  endfunction

  function automatic word_t ch_to_word(input ch_vec_t c);
    word_t w;
    w = '0;
    w[EPF_RX_LSB +: EPF_NUM_EP] = c[EPF_NUM_EP-1:0];
    w[EPF_TX_LSB +: EPF_NUM_EP] = c[EPF_NCH-1:EPF_NUM_EP];
    return w;
  endfunction

  // Sticky bit update: a set beats a clear in the same cycle
  function automatic ch_vec_t sticky_next(input ch_vec_t cur, input ch_vec_t set,
                                          input ch_vec_t clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/epf_req_bits.sv
module epf_req_bits
  import epf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ch_vec_t set_i,
  input  ch_vec_t clr_i,
  output ch_vec_t pend_o
);
  ch_vec_t pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= sticky_next(pend_q, set_i, clr_i);
  end

  assign pend_o = pend_q;

  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_q) & ~$past(clr_i)) & ~pend_q) == '0));
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_i) & ~pend_q) == '0));
  // R4
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_i & ~set_i) & pend_q) == '0));
endmodule

// File: rtl/epf_arbiter.sv
module epf_arbiter
  import epf_pkg::*;
(
  input  ch_vec_t prime_pend_i,
  input  ch_vec_t flush_pend_i,
  input  ch_vec_t pkt_busy_i,
  output ch_vec_t prime_req_o,
  output ch_vec_t flush_req_o
);
  // Flush held off by a packet in flight; prime held off by a pending flush
  assign flush_req_o = flush_pend_i & ~pkt_busy_i;
  assign prime_req_o = prime_pend_i & ~flush_pend_i;
endmodule

// File: rtl/epf_status.sv
module epf_status
  import epf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ch_vec_t primed_i,
  input  ch_vec_t flushed_i,
  output ch_vec_t stat_o
);
  ch_vec_t stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= sticky_next(stat_q, primed_i, flushed_i);
  end

  assign stat_o = stat_q;

  // R4
  stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(primed_i) & ~stat_q) == '0));
  // R6
  stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flushed_i & ~primed_i) & stat_q) == '0));
endmodule

// File: rtl/ep_prime_flush_ctrl.sv
module ep_prime_flush_ctrl
  import epf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [EPF_AW-1:0]      reg_addr,
  input  logic                   reg_we,
  input  logic [EPF_DW-1:0]      reg_wdata,
  output logic [EPF_DW-1:0]      reg_rdata,
  output logic [EPF_NCH-1:0]     prime_req,
  input  logic [EPF_NCH-1:0]     prime_done,
  output logic [EPF_NCH-1:0]     flush_req,
  input  logic [EPF_NCH-1:0]     flush_done,
  input  logic [EPF_NCH-1:0]     pkt_busy,
  input  logic [EPF_NCH-1:0]     auto_prime
);
  reg_sel_e sel;
  ch_vec_t  wr_bits, wr_prime, wr_flush;
  ch_vec_t  prime_set, prime_ok, flush_ok;
  ch_vec_t  prime_pend, flush_pend, stat;
  word_t    rd_next, rdata_q;

  assign sel      = reg_sel_e'(reg_addr);
  assign wr_bits  = word_to_ch(reg_wdata);
  assign wr_prime = (reg_we && sel == SEL_PRIME) ? wr_bits : '0;
  assign wr_flush = (reg_we && sel == SEL_FLUSH) ? wr_bits : '0;

  // Named internal events
  assign prime_set = wr_prime | auto_prime;
  assign prime_ok  = prime_done & prime_req;
  assign flush_ok  = flush_done & flush_req;

  epf_req_bits u_prime (
    .clk(clk), .rst_n(rst_n), .set_i(prime_set), .clr_i(prime_ok), .pend_o(prime_pend));

  epf_req_bits u_flush (
    .clk(clk), .rst_n(rst_n), .set_i(wr_flush), .clr_i(flush_ok), .pend_o(flush_pend));

  epf_arbiter u_arb (
    .prime_pend_i(prime_pend), .flush_pend_i(flush_pend), .pkt_busy_i(pkt_busy),
    .prime_req_o(prime_req), .flush_req_o(flush_req));

  epf_status u_stat (
    .clk(clk), .rst_n(rst_n), .primed_i(prime_ok), .flushed_i(flush_ok), .stat_o(stat));

  always_comb begin
    case (sel)
      SEL_PRIME: rd_next = ch_to_word(prime_pend);
      SEL_FLUSH: rd_next = ch_to_word(flush_pend);
      SEL_STAT:  rd_next = ch_to_word(stat);
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_next;
  end

  assign reg_rdata = rdata_q;

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~ch_to_word('1)) == '0);
  // R7
  flush_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prime_req & flush_pend) == '0);
  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req & pkt_busy) == '0);
  // R11
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_STAT) |=> (reg_rdata == ch_to_word($past(stat))));
endmodule

// File: tb/tb_ep_prime_flush_ctrl.sv
`timescale 1ns/1ps
module tb_ep_prime_flush_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  prime_req, flush_req;
  logic [5:0]  prime_done = '0, flush_done = '0, pkt_busy = '0, auto_prime = '0;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ep_prime_flush_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prime_req(prime_req),
    .prime_done(prime_done), .flush_req(flush_req), .flush_done(flush_done),
    .pkt_busy(pkt_busy), .auto_prime(auto_prime));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    chk(req, reg_rdata, exp);
  endtask

  task automatic pulse_prime_done(input logic [5:0] v);
    prime_done = v; @(posedge clk); @(negedge clk); prime_done = '0;
  endtask

  task automatic pulse_flush_done(input logic [5:0] v);
    flush_done = v; @(posedge clk); @(negedge clk); flush_done = '0;
  endtask

  task automatic t_reset();
    rd_chk("R1 prime", 2'd0, 32'h0);
    rd_chk("R1 flush", 2'd1, 32'h0);
    rd_chk("R1 status", 2'd2, 32'h0);
    chk("R1 reqs", {26'd0, prime_req}, {26'd0, flush_req});
    chk("R1 prime_req", {26'd0, prime_req}, 32'h0);
  endtask

  task automatic t_prime_basic();
    wr(2'd0, 32'hFFF8_FFF8);
    wr(2'd1, 32'hFFF8_FFF8);
    rd_chk("R2 rsvd prime", 2'd0, 32'h0);
    rd_chk("R2 rsvd flush", 2'd1, 32'h0);
    wr(2'd0, 32'h0004_0001);
    chk("R3 prime_req", {26'd0, prime_req}, 32'h21);
    rd_chk("R2 prime map", 2'd0, 32'h0004_0001);
    wr(2'd0, 32'h0);
    rd_chk("R3 write zero", 2'd0, 32'h0004_0001);
    pulse_prime_done(6'b100001);
    chk("R4 req drop", {26'd0, prime_req}, 32'h0);
    rd_chk("R4 prime clr", 2'd0, 32'h0);
    rd_chk("R4 status set", 2'd2, 32'h0004_0001);
    rd_chk("R11 addr3", 2'd3, 32'h0);
  endtask

  task automatic t_status_ro();
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd2, 32'h0);
    rd_chk("R10 status", 2'd2, 32'h0004_0001);
    rd_chk("R10 prime", 2'd0, 32'h0);
  endtask

  task automatic t_done_ignored();
    pulse_prime_done(6'b000010);
    pulse_flush_done(6'b100000);
    rd_chk("R12 status", 2'd2, 32'h0004_0001);
    rd_chk("R12 prime", 2'd0, 32'h0);
  endtask

  task automatic t_flush_busy();
    pkt_busy = 6'b000001;
    wr(2'd1, 32'h1);
    chk("R5 held", {26'd0, flush_req}, 32'h0);
    repeat (3) @(negedge clk);
    rd_chk("R5 pending", 2'd1, 32'h1);
    pkt_busy = '0;
    #1 chk("R5 released", {26'd0, flush_req}, 32'h1);
    pulse_flush_done(6'b000001);
    rd_chk("R6 flush clr", 2'd1, 32'h0);
    rd_chk("R6 status clr", 2'd2, 32'h0004_0000);
  endtask

  task automatic t_flush_first();
    wr(2'd1, 32'h2);
    wr(2'd0, 32'h2);
    chk("R7 prime held", {26'd0, prime_req}, 32'h0);
    chk("R7 flush go", {26'd0, flush_req}, 32'h2);
    pulse_flush_done(6'b000010);
    chk("R7 prime after", {26'd0, prime_req}, 32'h2);
    pulse_prime_done(6'b000010);
    rd_chk("R7 status", 2'd2, 32'h0004_0002);
  endtask

  task automatic t_auto();
    auto_prime = 6'b010000; @(posedge clk); @(negedge clk); auto_prime = '0;
    chk("R8 req", {26'd0, prime_req}, 32'h10);
    rd_chk("R8 prime", 2'd0, 32'h0002_0000);
    pulse_prime_done(6'b010000);
    rd_chk("R8 clr", 2'd0, 32'h0);
    rd_chk("R8 status", 2'd2, 32'h0006_0002);
  endtask

  task automatic t_write_wins();
    wr(2'd0, 32'h1);
    prime_done = 6'b000001;
    wr(2'd0, 32'h1);
    prime_done = '0;
    chk("R9 req kept", {26'd0, prime_req}, 32'h1);
    rd_chk("R9 prime kept", 2'd0, 32'h1);
    rd_chk("R9 status", 2'd2, 32'h0006_0003);
    pulse_prime_done(6'b000001);
    rd_chk("R9 cleared", 2'd0, 32'h0);
  endtask

  task automatic t_latency();
    reg_addr = 2'd2;
    @(posedge clk); @(negedge clk);
    reg_addr = 2'd0;
    #2 chk("R11 no change yet", reg_rdata, 32'h0006_0003);
    @(posedge clk); @(negedge clk);
    chk("R11 after edge", reg_rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prime_basic();
    t_status_ro();
    t_done_ignored();
    t_flush_busy();
    t_flush_first();
    t_auto();
    t_write_wins();
    t_latency();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule